// File: doc/BRIEF.md
# Diagnostic Panel Control Peripheral

This block sits on a 16-bit address, 8-bit data bus and controls a diagnostic front panel. It claims a 32-byte address window. The lower half of the window is a bank of eight single-bit control lines. Software sets or clears one line by writing to that line's address, so it never reads, modifies and writes back. Bits 3:1 of the address select the line. Bit 0 selects the direction: an even address asserts the line and an odd address deasserts it. The value on the data bus plays no part in this.

Line 3 enables the hex displays, so asserting it unblanks them and deasserting it blanks them. Lines 4 to 7 drive the four decimal points. Lines 0 to 2 are decoded, but nothing is attached to them. The upper half of the window is one register, repeated at every address in that half. A write there loads the hex display data. A read there returns the DIP-switch setting after it has passed through a two-flop synchroniser.

Top module: `diag_panel_ctrl`

## Requirements
- R1: busHit is 1 exactly when busAddr lies in 0xF100..0xF11F, whatever the strobes are doing, and 0 for every other address.
- R2: At a rising edge with busWr=1 and busAddr in 0xF100..0xF10F, the line numbered busAddr[3:1] becomes 1 if busAddr[0]=0 and 0 if busAddr[0]=1. The new value shows on the outputs after that edge, and every other line keeps its value.
- R3: Line 3 is the display enable and dispBlank is its inverse. A write to 0xF106 drives dispBlank to 0, and a write to 0xF107 drives it to 1.
- R4: Line 4+k drives dpOut[k] for k=0..3. The set/clear address pairs are 0xF108/9, 0xF10A/B, 0xF10C/D and 0xF10E/F.
- R5: For a line-control write, the busWrData value has no effect. A read strobe without a write strobe changes no line.
- R6: A write anywhere in 0xF110..0xF11F loads busWrData into dispData, which shows it after that edge. No other access changes dispData.
- R7: While busRd=1 and busAddr is in 0xF110..0xF11F, busRdData shows dipIn as it was sampled two rising edges earlier. A change on dipIn appears after the second edge and not after the first.
- R8: busRdData is 0 for reads of 0xF100..0xF10F, for addresses outside the window, and whenever busRd=0.
- R9: While rstN=0 and after reset, dispBlank=1, dpOut=0 and dispData=0, and the synchroniser holds 0.
- R10: A write outside the window changes neither the lines nor dispData.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 16 | Bus address |
| busWrData | input | 8 | Bus write data |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busRdData | output | 8 | Read data, combinational |
| busHit | output | 1 | Address lies in the block's window |
| dipIn | input | 8 | DIP switch levels from the panel, asynchronous |
| dispBlank | output | 1 | Display blanking, 1 = blanked |
| dpOut | output | 4 | Decimal points 1..4 |
| dispData | output | 8 | Hex display data register |

## Verification
The bench uses the default parameters: eight lines, a two-stage synchroniser and a 0xF100 base. With only 32 decoded addresses, it can sweep the whole 64K address space for hit and read data. It can also exercise every line-control address in three orderings, each with contrasting data values. Because the synchroniser is only two stages deep, the bench can test the exact cycle at which a DIP change becomes visible.

// File: rtl/diag_panel_pkg.sv
package diag_panel_pkg;
  localparam int PANEL_LINES = 8;
  localparam int LINE_IDX_W  = $clog2(PANEL_LINES);

  typedef struct packed {
    logic                  lineSet;
    logic                  lineClr;
    logic [LINE_IDX_W-1:0] lineIdx;
    logic                  dispLoad;
    logic                  dipRead;
  } panelStrobe_t;
endpackage

// File: rtl/diag_panel_decode.sv
module diag_panel_decode
  import diag_panel_pkg::*;
#(
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = 16'hF100
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output panelStrobe_t      strobe,
  output logic              hit
);
  // window = line half (2 addresses per line) plus equally sized register half
  localparam int WIN_W = LINE_IDX_W + 2;

  logic inWin;
  logic lineArea;
  logic dipArea;

  always_comb begin
    inWin    = (busAddr[ADDR_W-1:WIN_W] == BASE[ADDR_W-1:WIN_W]);
    lineArea = inWin & ~busAddr[WIN_W-1];
    dipArea  = inWin &  busAddr[WIN_W-1];

    strobe.lineSet  = busWr & lineArea & ~busAddr[0];
    strobe.lineClr  = busWr & lineArea &  busAddr[0];
    strobe.lineIdx  = busAddr[LINE_IDX_W:1];
    strobe.dispLoad = busWr & dipArea;
    strobe.dipRead  = busRd & dipArea;
    hit             = inWin;
  end
endmodule

// File: rtl/diag_panel_dpath.sv
module diag_panel_dpath
  import diag_panel_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int BLANK_LINE  = 3,
  parameter int DP_FIRST    = 4,
  parameter int DP_COUNT    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  panelStrobe_t      strobe,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] dipIn,
  output logic [DATA_W-1:0] busRdData,
  output logic              dispBlank,
  output logic [DP_COUNT-1:0] dpOut,
  output logic [DATA_W-1:0] dispData
);
  localparam logic [LINE_IDX_W-1:0] BLANK_IDX = LINE_IDX_W'(BLANK_LINE);

  logic                dispOn;
  logic [DP_COUNT-1:0] dpState;
  logic [DATA_W-1:0]   dispReg;
  logic [DATA_W-1:0]   dipSync [SYNC_STAGES];

  // display enable line: set lights the displays
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        dispOn <= 1'b0;
    else if (strobe.lineSet && strobe.lineIdx == BLANK_IDX) dispOn <= 1'b1;
    else if (strobe.lineClr && strobe.lineIdx == BLANK_IDX) dispOn <= 1'b0;
  end

  // one flop per decimal point line
  for (genvar g = 0; g < DP_COUNT; g++) begin : gDp
    localparam logic [LINE_IDX_W-1:0] MY_IDX = LINE_IDX_W'(DP_FIRST + g);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                          dpState[g] <= 1'b0;
      else if (strobe.lineSet && strobe.lineIdx == MY_IDX) dpState[g] <= 1'b1;
      else if (strobe.lineClr && strobe.lineIdx == MY_IDX) dpState[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dispReg <= '0;
    else if (strobe.dispLoad) dispReg <= busWrData;
  end

  // switch input synchroniser chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dipSync[s] <= '0;
      else if (s == 0) dipSync[s] <= dipIn;
      else             dipSync[s] <= dipSync[(s == 0) ? 0 : s-1];
    end
  end

  always_comb begin
    busRdData = strobe.dipRead ? dipSync[SYNC_STAGES-1] : '0;
    dispBlank = ~dispOn;
    dpOut     = dpState;
    dispData  = dispReg;
  end
endmodule

// File: rtl/diag_panel_ctrl.sv
module diag_panel_ctrl
  import diag_panel_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                DATA_W      = 8,
  parameter logic [ADDR_W-1:0] BASE        = 16'hF100,
  parameter int                SYNC_STAGES = 2,
  parameter int                BLANK_LINE  = 3,
  parameter int                DP_FIRST    = 4,
  parameter int                DP_COUNT    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRd,
  input  logic              busWr,
  output logic [DATA_W-1:0] busRdData,
  output logic              busHit,
  input  logic [DATA_W-1:0] dipIn,
  output logic              dispBlank,
  output logic [DP_COUNT-1:0] dpOut,
  output logic [DATA_W-1:0] dispData
);
  panelStrobe_t strobe;

  diag_panel_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) decode_i (
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .strobe(strobe), .hit(busHit)
  );

  diag_panel_dpath #(
    .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .BLANK_LINE(BLANK_LINE),
    .DP_FIRST(DP_FIRST), .DP_COUNT(DP_COUNT)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWrData(busWrData),
    .dipIn(dipIn), .busRdData(busRdData), .dispBlank(dispBlank),
    .dpOut(dpOut), .dispData(dispData)
  );
endmodule

// File: rtl/diag_panel_ctrl_chk.sv
module diag_panel_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic [15:0] busAddr,
  input logic [7:0]  busWrData,
  input logic        busRd,
  input logic        busWr,
  input logic [7:0]  busRdData,
  input logic        busHit,
  input logic [7:0]  dipIn,
  input logic        dispBlank,
  input logic [3:0]  dpOut,
  input logic [7:0]  dispData
);
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  logic inLine, inDip;
  assign inLine = (busAddr >= 16'hF100) && (busAddr <= 16'hF10F);
  assign inDip  = (busAddr >= 16'hF110) && (busAddr <= 16'hF11F);

  AST_HIT_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    !(inLine || inDip) |-> !busHit);  // R1
  AST_DP1_SET: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == 16'hF108 |=> dpOut[0]);  // R4
  AST_DP4_CLR: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == 16'hF10F |=> !dpOut[3]);  // R2
  AST_BLANK_ON: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == 16'hF107 |=> dispBlank);  // R3
  AST_UNBLANK: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == 16'hF106 |=> !dispBlank);  // R3
  AST_LINES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && inLine) |=> $stable({dispBlank, dpOut}));  // R5
  AST_DISP_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    busWr && inDip |=> dispData == $past(busWrData));  // R6
  AST_DISP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(busWr && inDip) |=> $stable(dispData));  // R10
  AST_DIP_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    busRd && inDip && sinceRst >= 2'd2 |-> busRdData == $past(dipIn, 2));  // R7
  AST_RD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && inDip) |-> busRdData == 8'h00);  // R8
endmodule

bind diag_panel_ctrl diag_panel_ctrl_chk chk_i (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
  .busRd(busRd), .busWr(busWr), .busRdData(busRdData), .busHit(busHit),
  .dipIn(dipIn), .dispBlank(dispBlank), .dpOut(dpOut), .dispData(dispData)
);

// File: tb/diag_panel_ctrl_tb_top.sv
module diag_panel_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] busAddr = 16'h0000;
  logic [7:0]  busWrData = 8'h00;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busRdData;
  logic        busHit;
  logic [7:0]  dipIn = 8'h00;
  logic        dispBlank;
  logic [3:0]  dpOut;
  logic [7:0]  dispData;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] refLines = 8'h00;   // bench model of the eight lines
  logic [7:0] refDisp  = 8'h00;
  logic [7:0] dipNow   = 8'h00;

  always #10 clk = ~clk;  // 50 MHz

  diag_panel_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busRd(busRd), .busWr(busWr), .busRdData(busRdData), .busHit(busHit),
    .dipIn(dipIn), .dispBlank(dispBlank), .dpOut(dpOut), .dispData(dispData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic checkPanel(input string req);
    check(req, {31'd0, dispBlank}, {31'd0, ~refLines[3]});
    check(req, {28'd0, dpOut}, {28'd0, refLines[7:4]});
    check(req, {24'd0, dispData}, {24'd0, refDisp});
  endtask

  // drive at falling edge, one rising edge with strobe, sample at next falling edge
  task automatic busWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    if (a >= 16'hF100 && a <= 16'hF10F) refLines[a[3:1]] = ~a[0];
    if (a >= 16'hF110 && a <= 16'hF11F) refDisp = d;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin : stim
    // R9: state while in reset and after release
    repeat (3) @(negedge clk);
    checkPanel("R9 in reset");
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkPanel("R9 after reset");
    busRd = 1'b1; busAddr = 16'hF110;
    #1 check("R9 sync zero", {24'd0, busRdData}, 32'd0);
    busRd = 1'b0;

    // R1/R7/R8: full address sweep, no clock needed for combinational outputs
    dipIn = 8'hA5; dipNow = 8'hA5;
    repeat (3) @(negedge clk);
    for (int a = 0; a < 65536; a++) begin
      logic inW;
      busAddr = 16'(a);
      inW = (a >= 'hF100) && (a <= 'hF11F);
      busRd = a[0] ^ a[5];
      #1;
      check("R1 hit", {31'd0, busHit}, {31'd0, inW});
      if (busRd && a >= 'hF110 && a <= 'hF11F)
        check("R7 dip read", {24'd0, busRdData}, {24'd0, dipNow});
      else
        check("R8 zero read", {24'd0, busRdData}, 32'd0);
    end
    busRd = 1'b0;

    // R2/R3/R4: all sets ascending, then all clears descending, data varies (R5)
    for (int i = 0; i < 8; i++) begin
      busWrite(16'hF100 + 16'(2*i), 8'(i * 37));
      checkPanel("R2 set ascending");
    end
    for (int i = 7; i >= 0; i--) begin
      busWrite(16'hF101 + 16'(2*i), 8'hFF);
      checkPanel("R2 clear descending");
    end
    // scrambled order over all 16 line addresses, twice
    for (int i = 0; i < 32; i++) begin
      busWrite(16'hF100 + 16'((i * 7) % 16), (i % 2) ? 8'h00 : 8'hFF);
      checkPanel("R4 scrambled");
    end
    busWrite(16'hF106, 8'h00); checkPanel("R3 unblank");
    busWrite(16'hF107, 8'hFF); checkPanel("R3 blank");
    busWrite(16'hF106, 8'h55); checkPanel("R3 unblank again");

    // R5: read strobe alone on line addresses changes nothing
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      busAddr = 16'hF100 + 16'(i); busRd = 1'b1;
      @(negedge clk);
      busRd = 1'b0;
      checkPanel("R5 read no effect");
    end

    // R6: display register across every mirror address
    for (int i = 0; i < 16; i++) begin
      busWrite(16'hF110 + 16'(i), 8'((i * 29) ^ 8'h3C));
      checkPanel("R6 display load");
    end

    // R10: writes outside the window
    busWrite(16'hF120, 8'h11); checkPanel("R10 outside F120");
    busWrite(16'hF0FE, 8'h22); checkPanel("R10 outside F0FE");
    busWrite(16'h0108, 8'h33); checkPanel("R10 outside 0108");
    busWrite(16'hF300, 8'h44); checkPanel("R10 outside F300");

    // R7: synchroniser latency, several patterns
    for (int i = 0; i < 6; i++) begin
      logic [7:0] nv;
      nv = 8'(i * 83 + 1);
      @(negedge clk);
      busAddr = 16'hF11A; busRd = 1'b1;
      dipIn = nv;
      @(negedge clk);
      check("R7 not after one edge", {24'd0, busRdData}, {24'd0, dipNow});
      @(negedge clk);
      check("R7 after two edges", {24'd0, busRdData}, {24'd0, nv});
      dipNow = nv;
      busRd = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule